// File: doc/BRIEF.md
# Quarter-Rate IQ Phase and Amplitude Loop

This block closes a digital amplitude and phase loop around an intermediate-frequency signal whose frequency is exactly one quarter of the sample clock. Each clock brings one signed converter sample. Because the carrier advances by 90 degrees per sample, the incoming stream can be read as the repeating pattern I, Q, -I, -Q. The demodulator turns every group of four samples into one measured I/Q pair. It averages each component over its positive and negative occurrence.

A separate proportional-integral controller for each of I and Q compares the measured pair with its programmable setpoint. The controller forms a corrected drive value. A modulator then plays the corrected pair back out as I, Q, -I, -Q on successive clocks for the output converter. A shared two-bit phase counter keeps the input and output sequences aligned. With the loop disabled, the controllers are cleared and the setpoints pass to the modulator unchanged, so the drive runs open loop.

Top module: `iq_loop_top`

## Requirements
- R1: While reset is held, dac_out, meas_i, meas_q and pair_valid are all zero.
- R2: The k-th rising edge after reset (k from 0) captures adc_in as element k mod 4 of a group, in the order I, Q, -I, -Q. On the edge that captures element 3, meas_i becomes floor((s0 - s2)/2) and meas_q becomes floor((s1 - s3)/2). These values then hold for four clocks. pair_valid is high for exactly the one clock that follows that edge.
- R3: The value dac_out takes at the k-th edge after reset is corr_i, corr_q, -corr_i or -corr_q for k mod 4 = 0, 1, 2 or 3. The corrected pair computed from the group whose last sample is taken at edge m is used from edge m+2 onward, which is well under 30 clocks. The corrected pair is zero until the first update.
- R4: When loop_en is low at an update, the corrected pair becomes (sp_i, sp_q) exactly. On every clock with loop_en low, both integrators clear to zero, so a later enable with zero gains gives the setpoints back unchanged.
- R5: err_i = sp_i - meas_i and err_q = sp_q - meas_q at all times, DW+1 bits signed.
- R6: On each update with loop_en high, each channel computes e = sp - meas and integ' = sat(integ + ki*e). Its corrected value becomes clip(sp + floor((kp*e + integ') / 2^SHIFT)). The gains kp and ki are unsigned. The corrected values change only on updates.
- R7: The integrator is DW+GW+4 bits two's complement and saturates at its most positive and most negative values instead of wrapping. The corrected values and dac_out are clipped to ±(2^(DW-1)-1), so the most negative code never appears.
- R8: In closed loop through a plant that returns half the output after four clocks, with kp=64, ki=32 and SHIFT=8, both errors settle within ±4 after 300 updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Closes the loop when high |
| sp_i | input | DW | Signed in-phase setpoint |
| sp_q | input | DW | Signed quadrature setpoint |
| kp | input | GW | Unsigned proportional gain |
| ki | input | GW | Unsigned integral gain |
| adc_in | input | DW | Signed converter sample |
| dac_out | output | DW | Signed modulated drive sample |
| meas_i | output | DW | Measured in-phase component |
| meas_q | output | DW | Measured quadrature component |
| err_i | output | DW+1 | In-phase error, setpoint minus measurement |
| err_q | output | DW+1 | Quadrature error, setpoint minus measurement |
| pair_valid | output | 1 | One-clock pulse when a new pair is measured |

## Verification
The assertions assume that the sample stream starts its I, Q, -I, -Q pattern on the first edge after reset. They also assume that setpoints, gains and loop_en change only between groups, so each update sees one stable configuration. The stimulus drives samples and changes the configuration only at the falling edge that opens a new four-sample group. It mixes seeded random samples and gains with synthetic tones of known phase, full-scale patterns that drive the integrator into saturation, and a closed feedback path built from the drive output.

// File: rtl/iq_loop_pkg.sv
package iq_loop_pkg;

  // position of a sample within the quarter-rate carrier cycle
  typedef enum logic [1:0] {
    QP_I  = 2'd0,
    QP_Q  = 2'd1,
    QP_NI = 2'd2,
    QP_NQ = 2'd3
  } qphase_t;

  function automatic qphase_t qphase_next(input qphase_t p);
    return qphase_t'(p + 2'd1);
  endfunction

endpackage

// File: rtl/iq_demod.sv
module iq_demod
  import iq_loop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  qphase_t              ph,
  input  logic signed [DW-1:0] adc,
  output logic signed [DW-1:0] meas_i,
  output logic signed [DW-1:0] meas_q,
  output logic                 valid
);

  logic signed [DW-1:0] smp0, smp1, smp2;

  // floor of half the difference; full range fits back into DW bits
  function automatic logic signed [DW-1:0] half_diff(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b);
    logic signed [DW:0] d;
    d = {a[DW-1], a} - {b[DW-1], b};
    return d[DW:1];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp0   <= '0;
      smp1   <= '0;
      smp2   <= '0;
      meas_i <= '0;
      meas_q <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= (ph == QP_NQ);
      case (ph)
        QP_I:  smp0 <= adc;
        QP_Q:  smp1 <= adc;
        QP_NI: smp2 <= adc;
        default: begin
          meas_i <= half_diff(smp0, smp2);
          meas_q <= half_diff(smp1, adc);
        end
      endcase
    end
  end

endmodule

// File: rtl/iq_pi.sv
module iq_pi #(
  parameter int DW    = 16,
  parameter int GW    = 12,
  parameter int IW    = DW + GW + 4,
  parameter int SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic                 en,
  input  logic signed [DW-1:0] sp,
  input  logic signed [DW-1:0] meas,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  output logic signed [DW:0]   err,
  output logic signed [DW-1:0] corr,
  output logic signed [IW-1:0] integ
);

  localparam int EW  = DW + 1;
  localparam int PW  = DW + GW + 2;
  localparam int IW1 = IW + 1;
  localparam int IW2 = IW + 2;
  localparam logic signed [IW2-1:0] CLIP_HI = IW2'((2 ** (DW - 1)) - 1);
  localparam logic signed [IW2-1:0] CLIP_LO = -CLIP_HI;

  function automatic logic signed [IW-1:0] sat_integ(input logic signed [IW:0] v);
    if (v[IW] != v[IW-1])
      return v[IW] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
    return v[IW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] clip_out(input logic signed [IW2-1:0] v);
    if (v > CLIP_HI) return CLIP_HI[DW-1:0];
    if (v < CLIP_LO) return CLIP_LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [GW:0]     kp_s, ki_s;
  logic signed [PW-1:0]   err_w, kp_w, ki_w, p_term, i_term;
  logic signed [IW1-1:0]  integ_sum;
  logic signed [IW-1:0]   integ_nxt;
  logic signed [IW2-1:0]  ctl, total;
  logic signed [DW-1:0]   corr_nxt;

  assign err       = EW'(sp) - EW'(meas);
  assign kp_s      = {1'b0, kp};
  assign ki_s      = {1'b0, ki};
  assign err_w     = PW'(err);
  assign kp_w      = PW'(kp_s);
  assign ki_w      = PW'(ki_s);
  assign p_term    = err_w * kp_w;
  assign i_term    = err_w * ki_w;
  assign integ_sum = IW1'(integ) + IW1'(i_term);
  assign integ_nxt = sat_integ(integ_sum);
  assign ctl       = IW2'(p_term) + IW2'(integ_nxt);
  assign total     = IW2'(sp) + (ctl >>> SHIFT);
  assign corr_nxt  = clip_out(total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= '0;
      corr  <= '0;
    end else begin
      if (!en)      integ <= '0;
      else if (upd) integ <= integ_nxt;
      if (upd)      corr  <= en ? corr_nxt : sp;
    end
  end

endmodule

// File: rtl/iq_mod.sv
module iq_mod
  import iq_loop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  qphase_t              ph,
  input  logic signed [DW-1:0] ci,
  input  logic signed [DW-1:0] cq,
  output logic signed [DW-1:0] dac
);

  function automatic logic signed [DW-1:0] pick(input qphase_t p,
                                                input logic signed [DW-1:0] i_v,
                                                input logic signed [DW-1:0] q_v);
    case (p)
      QP_I:    return i_v;
      QP_Q:    return q_v;
      QP_NI:   return -i_v;
      default: return -q_v;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) dac <= '0;
    else        dac <= pick(ph, ci, cq);
  end

endmodule

// File: rtl/iq_loop_top.sv
module iq_loop_top
  import iq_loop_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GW    = 12,
  parameter int SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loop_en,
  input  logic signed [DW-1:0] sp_i,
  input  logic signed [DW-1:0] sp_q,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic signed [DW-1:0] adc_in,
  output logic signed [DW-1:0] dac_out,
  output logic signed [DW-1:0] meas_i,
  output logic signed [DW-1:0] meas_q,
  output logic signed [DW:0]   err_i,
  output logic signed [DW:0]   err_q,
  output logic                 pair_valid
);

  localparam int IW = DW + GW + 4;
  localparam int NCH = 2;

  qphase_t ph;

  logic signed [DW-1:0] sp_a    [NCH];
  logic signed [DW-1:0] meas_a  [NCH];
  logic signed [DW-1:0] corr_a  [NCH];
  logic signed [DW:0]   err_a   [NCH];
  logic signed [IW-1:0] integ_a [NCH];

  // named views used by the bound checker
  logic signed [DW-1:0] corr_i, corr_q;
  logic signed [IW-1:0] integ_i, integ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= QP_I;
    else        ph <= qphase_next(ph);
  end

  iq_demod #(.DW(DW)) u_demod (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph),
    .adc    (adc_in),
    .meas_i (meas_i),
    .meas_q (meas_q),
    .valid  (pair_valid)
  );

  assign sp_a[0]   = sp_i;
  assign sp_a[1]   = sp_q;
  assign meas_a[0] = meas_i;
  assign meas_a[1] = meas_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iq_pi #(.DW(DW), .GW(GW), .IW(IW), .SHIFT(SHIFT)) u_pi (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (pair_valid),
      .en    (loop_en),
      .sp    (sp_a[c]),
      .meas  (meas_a[c]),
      .kp    (kp),
      .ki    (ki),
      .err   (err_a[c]),
      .corr  (corr_a[c]),
      .integ (integ_a[c])
    );
  end

  assign err_i   = err_a[0];
  assign err_q   = err_a[1];
  assign corr_i  = corr_a[0];
  assign corr_q  = corr_a[1];
  assign integ_i = integ_a[0];
  assign integ_q = integ_a[1];

  iq_mod #(.DW(DW)) u_mod (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph),
    .ci    (corr_i),
    .cq    (corr_q),
    .dac   (dac_out)
  );

endmodule

// File: rtl/iq_loop_chk.sv
module iq_loop_chk
  import iq_loop_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 loop_en,
  input logic signed [DW-1:0] sp_i,
  input logic signed [DW-1:0] sp_q,
  input logic signed [DW-1:0] adc_in,
  input logic signed [DW-1:0] dac_out,
  input logic signed [DW-1:0] meas_i,
  input logic signed [DW-1:0] meas_q,
  input logic                 pair_valid,
  input qphase_t              ph,
  input logic signed [DW-1:0] corr_i,
  input logic signed [DW-1:0] corr_q,
  input logic signed [IW-1:0] integ_i,
  input logic signed [IW-1:0] integ_q
);

  logic signed [DW-1:0] d1, d2, d3, d4;
  logic signed [DW:0]   diff_i, diff_q;
  logic signed [DW-1:0] want_i, want_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= '0; d2 <= '0; d3 <= '0; d4 <= '0;
    end else begin
      d1 <= adc_in; d2 <= d1; d3 <= d2; d4 <= d3;
    end
  end

  assign diff_i = {d4[DW-1], d4} - {d2[DW-1], d2};
  assign diff_q = {d3[DW-1], d3} - {d1[DW-1], d1};
  assign want_i = diff_i[DW:1];
  assign want_q = diff_q[DW:1];

  assert_meas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (meas_i == want_i && meas_q == want_q));

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (ph == QP_I));

  assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  assert_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == QP_I) |-> (dac_out == -$past(dac_out, 2)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (integ_i == '0 && integ_q == '0));

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !loop_en) |=> (corr_i == $past(sp_i) && corr_q == $past(sp_q)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |=> ($stable(corr_i) && $stable(corr_q)));

  assert_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_out != {1'b1, {(DW-1){1'b0}}});

endmodule

bind iq_loop_top iq_loop_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loop_en    (loop_en),
  .sp_i       (sp_i),
  .sp_q       (sp_q),
  .adc_in     (adc_in),
  .dac_out    (dac_out),
  .meas_i     (meas_i),
  .meas_q     (meas_q),
  .pair_valid (pair_valid),
  .ph         (ph),
  .corr_i     (corr_i),
  .corr_q     (corr_q),
  .integ_i    (integ_i),
  .integ_q    (integ_q)
);

// File: tb/iq_loop_top_bench.sv
`timescale 1ns/1ps
module iq_loop_top_bench;

  localparam int DW = 16;
  localparam int GW = 12;
  localparam int SHIFT = 8;
  localparam int IW = DW + GW + 4;
  localparam int MAXP = 1024;
  localparam int WD_CYCLES = 200000;
  localparam longint OUT_LIM = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint INT_MAX = (64'sd1 <<< (IW - 1)) - 1;
  localparam longint INT_MIN = -(64'sd1 <<< (IW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_en = 1'b0;
  logic signed [DW-1:0] sp_i = '0, sp_q = '0, adc_in = '0;
  logic [GW-1:0] kp = '0, ki = '0;
  logic signed [DW-1:0] dac_out, meas_i, meas_q;
  logic signed [DW:0] err_i, err_q;
  logic pair_valid;

  always #2.5 clk = ~clk;

  iq_loop_top #(.DW(DW), .GW(GW), .SHIFT(SHIFT)) u_iq_loop_top (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .sp_i(sp_i), .sp_q(sp_q),
    .kp(kp), .ki(ki), .adc_in(adc_in), .dac_out(dac_out), .meas_i(meas_i),
    .meas_q(meas_q), .err_i(err_i), .err_q(err_q), .pair_valid(pair_valid)
  );

  int checks = 0;
  int failures = 0;
  int n = 0;
  int npairs = 0;
  bit pend = 0;
  longint pm_i, pm_q;
  longint m_integ_i = 0, m_integ_q = 0;
  longint hist_ci [MAXP];
  longint hist_cq [MAXP];
  logic signed [DW-1:0] dac_ring [4];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint half_diff(input longint a, input longint b);
    return (a - b) >>> 1;
  endfunction

  function automatic longint lim_out(input longint v);
    if (v > OUT_LIM) return OUT_LIM;
    if (v < -OUT_LIM) return -OUT_LIM;
    return v;
  endfunction

  function automatic longint lim_int(input longint v);
    if (v > INT_MAX) return INT_MAX;
    if (v < INT_MIN) return INT_MIN;
    return v;
  endfunction

  function automatic longint pi_step(input longint sp, input longint m, input bit en,
                                     input longint gp, input longint gi, inout longint acc);
    longint e;
    if (!en) begin
      acc = 0;
      return sp;
    end
    e = sp - m;
    acc = lim_int(acc + gi * e);
    return lim_out(sp + ((gp * e + acc) >>> SHIFT));
  endfunction

  function automatic longint exp_dac(input int k);
    longint ci, cq;
    if (k < 5) return 0;
    ci = hist_ci[(k - 5) / 4];
    cq = hist_cq[(k - 5) / 4];
    case (k % 4)
      0: return ci;
      1: return cq;
      2: return -ci;
      default: return -cq;
    endcase
  endfunction

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic cycle(input bit fb, input logic signed [DW-1:0] s_in, input string tag,
                       output logic signed [DW-1:0] s_used);
    if (fb) s_used = dac_ring[n % 4] >>> 1;
    else    s_used = s_in;
    adc_in = s_used;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "dac_out", longint'(dac_out), exp_dac(n));
    chk("R2", "pair_valid", longint'(pair_valid), longint'(n % 4 == 3));
    dac_ring[n % 4] = dac_out;
    n++;
  endtask

  task automatic run_pair(input bit fb, input longint s0, input longint s1,
                          input longint s2, input longint s3, input string tag);
    logic signed [DW-1:0] u [4];
    if (pend) begin
      hist_ci[npairs - 1] = pi_step(longint'(sp_i), pm_i, loop_en, longint'(kp), longint'(ki), m_integ_i);
      hist_cq[npairs - 1] = pi_step(longint'(sp_q), pm_q, loop_en, longint'(kp), longint'(ki), m_integ_q);
    end
    cycle(fb, DW'(s0), tag, u[0]);
    cycle(fb, DW'(s1), tag, u[1]);
    cycle(fb, DW'(s2), tag, u[2]);
    cycle(fb, DW'(s3), tag, u[3]);
    pm_i = half_diff(longint'(u[0]), longint'(u[2]));
    pm_q = half_diff(longint'(u[1]), longint'(u[3]));
    chk("R2", "meas_i", longint'(meas_i), pm_i);
    chk("R2", "meas_q", longint'(meas_q), pm_q);
    chk("R5", "err_i", longint'(err_i), longint'(sp_i) - pm_i);
    chk("R5", "err_q", longint'(err_q), longint'(sp_q) - pm_q);
    pend = 1;
    npairs++;
  endtask

  function automatic longint rnd_range(input int lo, input int hi);
    return longint'(lo) + longint'($urandom % (hi - lo + 1));
  endfunction

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    longint ai, aq;
    real th, amp;
    void'($urandom(32'd7321));
    for (int k = 0; k < 4; k++) dac_ring[k] = '0;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1", "dac_out", longint'(dac_out), 0);
    chk("R1", "meas_i", longint'(meas_i), 0);
    chk("R1", "meas_q", longint'(meas_q), 0);
    chk("R1", "pair_valid", longint'(pair_valid), 0);
    rst_n = 1'b1;

    // open loop tones of known phase: setpoints reach the output (R4, R3)
    loop_en = 1'b0;
    for (int p = 0; p < 24; p++) begin
      sp_i = DW'(rnd_range(-20000, 20000));
      sp_q = DW'(rnd_range(-20000, 20000));
      th   = real'($urandom % 360) * 3.14159265358979 / 180.0;
      amp  = real'(rnd_range(1000, 15000));
      ai   = longint'($rtoi(amp * $cos(th)));
      aq   = longint'($rtoi(amp * $sin(th)));
      run_pair(0, ai, aq, -ai, -aq, "R4");
      chk("R2", "tone I", longint'(meas_i), ai);
      chk("R2", "tone Q", longint'(meas_q), aq);
    end

    // full scale extremes in the demodulator (R2)
    run_pair(0, 32767, -32768, -32768, 32767, "R3");
    chk("R2", "fullscale I", longint'(meas_i), 32767);
    chk("R2", "fullscale Q", longint'(meas_q), -32768);

    // random samples with the output order checked (R3)
    for (int p = 0; p < 16; p++)
      run_pair(0, rnd_range(-32768, 32767), rnd_range(-32768, 32767),
               rnd_range(-32768, 32767), rnd_range(-32768, 32767), "R3");

    // enabled controller with random gains and samples (R6)
    loop_en = 1'b1;
    for (int p = 0; p < 150; p++) begin
      if (p % 10 == 0) begin
        kp = GW'($urandom);
        ki = GW'($urandom % 256);
      end
      sp_i = DW'(rnd_range(-20000, 20000));
      sp_q = DW'(rnd_range(-20000, 20000));
      run_pair(0, rnd_range(-32768, 32767), rnd_range(-32768, 32767),
               rnd_range(-32768, 32767), rnd_range(-32768, 32767), "R6");
    end

    // drive the integrator into positive then negative saturation (R7)
    kp = '1; ki = '1;
    sp_i = DW'(32767); sp_q = DW'(32767);
    for (int p = 0; p < 20; p++) run_pair(0, -32768, -32768, 32767, 32767, "R7");
    chk("R7", "clipped high", labs(longint'(dac_out)), OUT_LIM);
    sp_i = DW'(-32767); sp_q = DW'(-32767);
    for (int p = 0; p < 20; p++) run_pair(0, 32767, 32767, -32768, -32768, "R7");
    chk("R7", "clipped low", labs(longint'(dac_out)), OUT_LIM);

    // disabling clears the integrators; zero gains then return the setpoints (R4)
    loop_en = 1'b0;
    run_pair(0, 100, 200, -100, -200, "R4");
    loop_en = 1'b1; kp = '0; ki = '0;
    sp_i = DW'(rnd_range(-20000, 20000));
    sp_q = DW'(rnd_range(-20000, 20000));
    for (int p = 0; p < 4; p++) run_pair(0, 5000, -7000, -5000, 7000, "R4");

    // closed loop through a half-gain plant with four clocks of delay (R6, R8)
    loop_en = 1'b0;
    run_pair(0, 0, 0, 0, 0, "R4");
    loop_en = 1'b1; kp = GW'(64); ki = GW'(32);
    sp_i = DW'(6000); sp_q = DW'(-4000);
    for (int p = 0; p < 300; p++) run_pair(1, 0, 0, 0, 0, "R6");
    chk("R8", "err_i settled", longint'(labs(longint'(err_i)) <= 4), 1);
    chk("R8", "err_q settled", longint'(labs(longint'(err_q)) <= 4), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule